// File: doc/BRIEF.md
# Local Interrupt Pending Arbiter

This block sits next to the trap unit of a hart and decides whether a local interrupt should be taken, and with which cause code. There are six local sources: software, timer and external, each at machine and supervisor level. The block holds the interrupt-enable register. It builds the interrupt-pending register from the hardware lines and two software-writable bits. The result is gated with the global enable and the current privilege, and one winner is picked by a fixed priority.

The trap unit writes the enable and pending registers through two write strobes that share one data bus, and it reads both back on dedicated read buses. When an interrupt wins, the block raises `take` and presents a 4-bit `cause`. Both stay frozen until the trap unit pulses `ack`. In this design no interrupt is delegated, so every source traps to machine mode.

Top module: `irq_select`

## Requirements
- R1: Each source has the same bit position in the enable and pending registers: supervisor software 1, machine software 3, supervisor timer 5, machine timer 7, supervisor external 9, machine external 11.
- R2: A source can only win when its pending bit and its enable bit are both 1.
- R3: When `priv` is 2'b11 (machine mode), no interrupt is taken unless `glb_mie` is 1. When `priv` is below machine mode, interrupts are taken whatever the value of `glb_mie`.
- R4: When several sources qualify at once, the winner is chosen in this order, from highest to lowest: bit 11, bit 9, bit 3, bit 1, bit 7, bit 5.
- R5: `cause` is the bit index of the winning source.
- R6: Pending bits 5, 7, 9 and 11 always equal the lines `hw_stip`, `hw_mtip`, `hw_seip` and `hw_meip`. Writes through `wr_ip` do not change them.
- R7: A `wr_ip` strobe loads bits 1 and 3 of `wdata` into the software pending bits. A `wr_ie` strobe loads the enable register. Both take effect at the next clock edge.
- R8: Writes to reserved positions (bits 0, 2, 4, 6, 8 and 10) are ignored. These positions read as zero in both registers.
- R9: `take` rises one clock edge after a source qualifies. From then on, `take` and `cause` hold their values until `ack` is seen, even if the pending or enable inputs change.
- R10: An edge where `ack` is 1 clears `take`. The following edge evaluates the sources again.
- R11: Reset clears the enable register, both software pending bits and `take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_stip | input | 1 | Supervisor timer line |
| hw_mtip | input | 1 | Machine timer line |
| hw_seip | input | 1 | Supervisor external line |
| hw_meip | input | 1 | Machine external line |
| wr_ie | input | 1 | Write strobe for the enable register |
| wr_ip | input | 1 | Write strobe for the pending register |
| wdata | input | 12 | Write data for both registers |
| glb_mie | input | 1 | Global machine interrupt enable |
| priv | input | 2 | Current privilege (3 = machine, 1 = supervisor, 0 = user) |
| ack | input | 1 | Trap unit has accepted the take |
| mie_rd | output | 12 | Enable register read value |
| mip_rd | output | 12 | Pending register read value |
| take | output | 1 | Take an interrupt |
| cause | output | 4 | Cause code of the taken interrupt |

## Verification
The hardest situation to reach is a held take: a `take` already raised that must keep its old `cause` while a higher-priority source appears and the original source goes away. The stimulus gets there by raising a low-priority timer line with the machine global enable on. It then adds the machine external line and drops the timer line before it pulses `ack`. The priority order itself is covered by a full sweep of all 64 pending patterns against all 64 enable patterns. During each reconfiguration the global gate is held closed, so every check starts from a cleared take.

// File: rtl/irq_select.sv
module irq_select (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_stip,
  input  logic        hw_mtip,
  input  logic        hw_seip,
  input  logic        hw_meip,
  input  logic        wr_ie,
  input  logic        wr_ip,
  input  logic [11:0] wdata,
  input  logic        glb_mie,
  input  logic [1:0]  priv,
  input  logic        ack,
  output logic [11:0] mie_rd,
  output logic [11:0] mip_rd,
  output logic        take,
  output logic [3:0]  cause
);
  localparam logic [11:0] IE_MASK = 12'hAAA;
  localparam logic [1:0]  PRIV_M  = 2'b11;

  logic [11:0] ie_q;
  logic        ssip_q, msip_q;
  logic        gate;
  logic [11:0] elig;
  logic        any;
  logic [3:0]  sel;
  logic        take_q;
  logic [3:0]  cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= '0;
      ssip_q <= 1'b0;
      msip_q <= 1'b0;
    end else begin
      if (wr_ie) ie_q <= wdata & IE_MASK;
      if (wr_ip) begin
        ssip_q <= wdata[1];
        msip_q <= wdata[3];
      end
    end
  end

  assign mie_rd = ie_q;
  assign mip_rd = {hw_meip, 1'b0, hw_seip, 1'b0, hw_mtip, 1'b0,
                   hw_stip, 1'b0, msip_q, 1'b0, ssip_q, 1'b0};

  assign gate = glb_mie | (priv != PRIV_M);
  assign elig = ie_q & mip_rd & {12{gate}};
  assign any  = |elig;

  always_comb begin
    if      (elig[11]) sel = 4'd11;
    else if (elig[9])  sel = 4'd9;
    else if (elig[3])  sel = 4'd3;
    else if (elig[1])  sel = 4'd1;
    else if (elig[7])  sel = 4'd7;
    else               sel = 4'd5;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      cause_q <= '0;
    end else if (ack) begin
      take_q  <= 1'b0;
    end else if (!take_q && any) begin
      take_q  <= 1'b1;
      cause_q <= sel;
    end
  end

  assign take  = take_q;
  assign cause = cause_q;
endmodule

module irq_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        glb_mie,
  input logic [1:0]  priv,
  input logic        ack,
  input logic [11:0] mie_rd,
  input logic [11:0] mip_rd,
  input logic        take,
  input logic [3:0]  cause
);
  logic [11:0] elig_d;
  always_ff @(posedge clk) begin
    if (!rst_n) elig_d <= '0;
    else        elig_d <= mie_rd & mip_rd;
  end

  a_r2_rise_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> elig_d[cause]);
  a_r3_rise_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(glb_mie || (priv != 2'b11)));
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((mie_rd | mip_rd) & 12'h555) == 12'h000);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ack) |=> (take && $stable(cause)));
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !take);
endmodule

bind irq_select irq_select_chk i_chk (
  .clk(clk), .rst_n(rst_n), .glb_mie(glb_mie), .priv(priv), .ack(ack),
  .mie_rd(mie_rd), .mip_rd(mip_rd), .take(take), .cause(cause)
);

// File: tb/test_irq_select.sv
module test_irq_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_stip = 0, hw_mtip = 0, hw_seip = 0, hw_meip = 0;
  logic        wr_ie = 0, wr_ip = 0;
  logic [11:0] wdata = '0;
  logic        glb_mie = 0;
  logic [1:0]  priv = 2'b11;
  logic        ack = 0;
  logic [11:0] mie_rd, mip_rd;
  logic        take;
  logic [3:0]  cause;

  int total = 0;
  int bad = 0;

  irq_select i_irq_select (
    .clk(clk), .rst_n(rst_n), .hw_stip(hw_stip), .hw_mtip(hw_mtip),
    .hw_seip(hw_seip), .hw_meip(hw_meip), .wr_ie(wr_ie), .wr_ip(wr_ip),
    .wdata(wdata), .glb_mie(glb_mie), .priv(priv), .ack(ack),
    .mie_rd(mie_rd), .mip_rd(mip_rd), .take(take), .cause(cause)
  );

  always #5 clk = ~clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] spread(logic [5:0] v);
    logic [11:0] r = '0;
    for (int k = 0; k < 6; k++) r[2*k+1] = v[k];
    return r;
  endfunction

  function automatic int pick(logic [11:0] e);
    int order[6] = '{11, 9, 3, 1, 7, 5};
    for (int k = 0; k < 6; k++) if (e[order[k]]) return order[k];
    return -1;
  endfunction

  task automatic wr(bit to_ip, logic [11:0] d);
    wdata = d;
    if (to_ip) wr_ip = 1; else wr_ie = 1;
    tick();
    wr_ip = 0;
    wr_ie = 0;
  endtask

  task automatic clear_take();
    glb_mie = 0;
    priv = 2'b11;
    ack = 1;
    tick();
    ack = 0;
  endtask

  task automatic set_hw(logic [11:0] p);
    hw_stip = p[5];
    hw_mtip = p[7];
    hw_seip = p[9];
    hw_meip = p[11];
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] en12, pd12, el;
    int exp;
    tick(3);
    rst_n = 1;
    tick();
    // R11 reset state
    chk(take == 0, "R11 take after reset", take, 0);
    chk(mie_rd == 0, "R11 enable after reset", mie_rd, 0);
    chk(mip_rd == 0, "R11 pending after reset", mip_rd, 0);

    // R8 reserved bits ignored, R7 writable bits
    wr(0, 12'hFFF);
    chk(mie_rd == 12'hAAA, "R8 R7 enable write all ones", mie_rd, 12'hAAA);
    wr(1, 12'hFFF);
    chk(mip_rd == 12'h00A, "R8 R6 pending write all ones", mip_rd, 12'h00A);
    wr(1, 12'h000);
    chk(mip_rd == 12'h000, "R7 pending software clear", mip_rd, 0);
    // R6 hw bits follow lines, not writes
    set_hw(12'hAA0);
    wr(1, 12'h000);
    chk(mip_rd == 12'hAA0, "R6 hardware pending read-only", mip_rd, 12'hAA0);
    set_hw(12'h000);
    #1;
    chk(mip_rd == 12'h000, "R6 hardware pending follows line", mip_rd, 0);

    // R1 R2 R4 R5 full sweep
    for (int en = 0; en < 64; en++) begin
      for (int pd = 0; pd < 64; pd++) begin
        clear_take();
        en12 = spread(en[5:0]);
        pd12 = spread(pd[5:0]);
        wr(0, en12);
        wr(1, pd12);
        set_hw(pd12);
        glb_mie = 1;
        tick(2);
        el = en12 & pd12;
        exp = pick(el);
        if (exp < 0)
          chk(take == 0, "R2 no qualifying source", take, 0);
        else
          chk(take == 1 && int'(cause) == exp, "R4 R5 R1 winner", {take, cause}, {1'b1, exp[3:0]});
      end
    end

    // R3 global gate
    clear_take();
    set_hw(12'h000);
    wr(1, 12'h000);
    wr(0, 12'hAAA);
    hw_mtip = 1;
    tick(2);
    chk(take == 0, "R3 machine mode gated by global enable", take, 0);
    priv = 2'b00;
    tick();
    chk(take == 1 && cause == 7, "R3 user mode ignores global enable", {take, cause}, {1'b1, 4'd7});
    clear_take();
    priv = 2'b01;
    tick();
    chk(take == 1 && cause == 7, "R3 supervisor mode ignores global enable", {take, cause}, {1'b1, 4'd7});

    // R9 hold, R10 ack
    clear_take();
    hw_mtip = 0;
    hw_stip = 1;
    glb_mie = 1;
    tick();
    chk(take == 1 && cause == 5, "R9 take one edge after qualify", {take, cause}, {1'b1, 4'd5});
    hw_meip = 1;
    tick(2);
    chk(take == 1 && cause == 5, "R9 hold against higher priority", {take, cause}, {1'b1, 4'd5});
    hw_stip = 0;
    tick(2);
    chk(take == 1 && cause == 5, "R9 hold after source drops", {take, cause}, {1'b1, 4'd5});
    ack = 1;
    tick();
    ack = 0;
    chk(take == 0, "R10 ack clears take", take, 0);
    tick();
    chk(take == 1 && cause == 11, "R10 re-evaluate after ack", {take, cause}, {1'b1, 4'd11});

    // R11 reset mid-run
    rst_n = 0;
    tick();
    rst_n = 1;
    chk(take == 0 && mie_rd == 0, "R11 reset clears state", {take, mie_rd}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule